// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block makes the serial clock for an SPI master from the system clock. It uses two programmable stages. A prescaler divides the system clock down to a low-speed peripheral rate, and it produces one enable pulse per low-speed period. A baud divider then counts those pulses to shape each half of the serial clock. The divide ratio comes from a 7-bit baud value. Values from 3 up give a divide of value plus one. The three smallest values all clamp to a divide of 4. Each serial clock period has a high half and then a low half. When the divide is odd, the high half is the longer one.

Both settings are loaded through a single-cycle write port. A select input picks which setting a write updates. A new setting waits in a pending register and only goes live at the next rising edge of the serial clock, so a write never shortens or stretches a half-period already in progress. Besides the serial clock, the block emits a one-cycle tick on every edge of the serial clock. A separate shift engine can use this tick to launch and capture data bits. When the enable input is low, the serial clock idles low, both counters are held cleared, and the pending settings pass straight through to the live settings.

Top module: `spi_baud_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `sclk` and `bit_tick` are low. Both settings reset to 0, so that with `en` high the serial clock is high for 2 clock cycles and low for 2 clock cycles.
- R2: For a baud value B from 3 to 127 (prescale setting 0), one serial clock period lasts B+1 clock cycles. The high half is ceil((B+1)/2) cycles and the low half is floor((B+1)/2) cycles.
- R3: Baud values 0, 1 and 2 all give a divide of 4, with each half lasting 2 low-speed periods. No half-period of the serial clock is ever shorter than 2 clock cycles.
- R4: A prescale setting V of 0 gives a low-speed period of 1 clock cycle. Any other V gives 2×V cycles. Every half-period is its length in low-speed periods multiplied by this value.
- R5: With an odd divide, the high half lasts exactly one low-speed period longer than the low half.
- R6: While `en` is high, `bit_tick` is high for exactly the clock cycles in which `sclk` has just changed level, and low otherwise.
- R7: A setting written during an active period does not change the current high or low half. It first applies to the high half that begins at the next rising edge of `sclk`.
- R8: One cycle after `en` is sampled low, `sclk` and `bit_tick` are low and stay low while `en` stays low. After `en` returns high, the first rising edge of `sclk` is seen after floor(D/2)×P cycles, where D is the baud divide and P is the prescale ratio.
- R9: A write made while `en` is low, followed by at least one more disabled cycle, is fully in effect from the first period after enabling.
- R10: Prescale setting 1 with baud value 14 gives a 30-cycle serial period, high for 16 cycles and low for 14. This is a 5 MHz serial clock from a 150 MHz system clock.
- R11: `wr_sel`=1 writes `wr_data[6:0]` as the baud value. `wr_sel`=0 writes `wr_data[3:0]` as the prescale setting and ignores `wr_data[6:4]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low idles the clock and clears the counters |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 1 | 0: prescale setting, 1: baud value |
| wr_data | input | 7 | Write data |
| sclk | output | 1 | Serial clock, idles low |
| bit_tick | output | 1 | One-cycle pulse on each edge of sclk |

## Verification
The assertions assume that `en` only changes level cleanly at clock edges. They also assume that nothing outside the block forces `sclk`. Their claims about minimum half-period width therefore apply only to cycles in which `en` stays high. The bench drives `en` and every write strobe at the falling clock edge, so each input is held steady across a full rising edge. It waits one disabled cycle after any write it expects to see applied immediately on enable. It also re-synchronises to a fresh rising edge of `sclk` before it measures a new setting.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

  typedef enum logic {
    SEL_PRESCALE = 1'b0,
    SEL_BAUD     = 1'b1
  } cfg_sel_e;

  localparam int MIN_DIV   = 4;
  localparam int CLAMP_TOP = 2;

  // divide applied by the baud stage for a register value
  function automatic int baud_ratio(input int b);
    return (b <= CLAMP_TOP) ? MIN_DIV : b + 1;
  endfunction

  // clock cycles per low-speed period for a prescale setting
  function automatic int pre_ratio(input int v);
    return (v == 0) ? 1 : 2 * v;
  endfunction

endpackage

// File: rtl/spi_baud_cfg.sv
module spi_baud_cfg
  import spi_baud_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int BAUD_W = 7,
  parameter int PDIV_W = 5,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BAUD_W-1:0] wr_data,
  input  logic              period_start,
  output logic [PDIV_W-1:0] pdiv_last,
  output logic [LEN_W-1:0]  hi_len,
  output logic [LEN_W-1:0]  lo_len
);

  logic [PRE_W-1:0]  pend_pre;
  logic [BAUD_W-1:0] pend_baud;
  logic              load;
  int                div_n;
  int                pre_n;

  // pending registers: written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_pre  <= '0;
      pend_baud <= '0;
    end else if (wr_en) begin
      if (cfg_sel_e'(wr_sel) == SEL_BAUD) pend_baud <= wr_data;
      else                               pend_pre  <= wr_data[PRE_W-1:0];
    end
  end

  assign load = !en || period_start;

  always_comb begin
    div_n = baud_ratio(int'(pend_baud));
    pre_n = pre_ratio(int'(pend_pre));
  end

  // live settings: follow pending while idle, else only at period start
  always_ff @(posedge clk) begin
    if (rst) begin
      pdiv_last <= PDIV_W'(pre_ratio(0) - 1);
      hi_len    <= LEN_W'((baud_ratio(0) + 1) / 2);
      lo_len    <= LEN_W'(baud_ratio(0) / 2);
    end else if (load) begin
      pdiv_last <= PDIV_W'(pre_n - 1);
      hi_len    <= LEN_W'((div_n + 1) / 2);
      lo_len    <= LEN_W'(div_n / 2);
    end
  end

endmodule

// File: rtl/spi_prescale.sv
module spi_prescale #(
  parameter int PDIV_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PDIV_W-1:0] pdiv_last,
  output logic              lsp_tick
);

  logic [PDIV_W-1:0] pcnt;

  assign lsp_tick = en && (pcnt == pdiv_last);

  always_ff @(posedge clk) begin
    if (rst || !en)    pcnt <= '0;
    else if (lsp_tick) pcnt <= '0;
    else               pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/spi_phase_gen.sv
module spi_phase_gen #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lsp_tick,
  input  logic [LEN_W-1:0] hi_len,
  input  logic [LEN_W-1:0] lo_len,
  output logic             sclk,
  output logic             bit_tick,
  output logic             period_start
);

  logic [LEN_W-1:0] bcnt;
  logic [LEN_W-1:0] phase_last;
  logic             phase_end;

  assign phase_last   = (sclk ? hi_len : lo_len) - 1'b1;
  assign phase_end    = en && lsp_tick && (bcnt == phase_last);
  assign period_start = phase_end && !sclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sclk     <= 1'b0;
      bit_tick <= 1'b0;
      bcnt     <= '0;
    end else begin
      bit_tick <= phase_end;
      if (phase_end) begin
        sclk <= !sclk;
        bcnt <= '0;
      end else if (lsp_tick) begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int PRE_W  = 4,
  parameter int BAUD_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BAUD_W-1:0] wr_data,
  output logic              sclk,
  output logic              bit_tick
);

  localparam int MAX_PRE = 2 * ((1 << PRE_W) - 1);
  localparam int PDIV_W  = $clog2(MAX_PRE);
  localparam int LEN_W   = BAUD_W;

  logic [PDIV_W-1:0] pdiv_last;
  logic [LEN_W-1:0]  hi_len;
  logic [LEN_W-1:0]  lo_len;
  logic              lsp_tick;
  logic              period_start;

  spi_baud_cfg #(
    .PRE_W (PRE_W),
    .BAUD_W(BAUD_W),
    .PDIV_W(PDIV_W),
    .LEN_W (LEN_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .period_start(period_start),
    .pdiv_last   (pdiv_last),
    .hi_len      (hi_len),
    .lo_len      (lo_len)
  );

  spi_prescale #(.PDIV_W(PDIV_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .pdiv_last(pdiv_last),
    .lsp_tick (lsp_tick)
  );

  spi_phase_gen #(.LEN_W(LEN_W)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .lsp_tick    (lsp_tick),
    .hi_len      (hi_len),
    .lo_len      (lo_len),
    .sclk        (sclk),
    .bit_tick    (bit_tick),
    .period_start(period_start)
  );

endmodule

// File: rtl/spi_baud_gen_chk.sv
module spi_baud_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic sclk,
  input logic bit_tick
);

  // R6
  tick_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && (sclk != $past(sclk))) |-> bit_tick);

  // R6
  tick_only_edge_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> (sclk != $past(sclk)));

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sclk && !bit_tick));

  // R3
  min_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && en) |=> sclk);

  // R3
  min_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sclk) && en && $past(en)) |=> !sclk);

endmodule

bind spi_baud_gen spi_baud_gen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .sclk    (sclk),
  .bit_tick(bit_tick)
);

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [6:0] wr_data = '0;
  logic       sclk;
  logic       bit_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_baud_gen u_spi_baud_gen (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sclk(sclk), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input bit sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = 7'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    while (sclk) @(negedge clk);
    while (!sclk) @(negedge clk);
  endtask

  // measures one full high and low half starting at a fresh rising edge
  task automatic measure(input int hi_exp, input int lo_exp, input string req);
    int h = 0;
    int l = 0;
    wait_rise();
    wait_rise();
    while (sclk) begin h++; @(negedge clk); end
    while (!sclk) begin l++; @(negedge clk); end
    check(h == hi_exp, req, "high cycles", h, hi_exp);
    check(l == lo_exp, req, "low cycles", l, lo_exp);
  endtask

  function automatic int pratio(input int v);
    return ((v & 15) == 0) ? 1 : 2 * (v & 15);
  endfunction

  function automatic int dratio(input int b);
    return (b <= 2) ? 4 : b + 1;
  endfunction

  task automatic run_cfg(input int pre, input int baud, input string req);
    int p = pratio(pre);
    int d = dratio(baud);
    write_cfg(1'b0, pre);
    write_cfg(1'b1, baud);
    measure(((d + 1) / 2) * p, (d / 2) * p, req);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    check(bit_tick == 1'b0, "R1", "tick in reset", int'(bit_tick), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);
    en = 1'b1;
    measure(2, 2, "R1");
  endtask

  task automatic test_divides();
    run_cfg(0, 3, "R2");
    run_cfg(0, 9, "R2");
    run_cfg(0, 127, "R2");
    run_cfg(0, 0, "R3");
    run_cfg(0, 1, "R3");
    run_cfg(0, 2, "R3");
    run_cfg(0, 4, "R5");
    run_cfg(0, 6, "R5");
    run_cfg(3, 3, "R4");
    run_cfg(15, 4, "R4");
  endtask

  task automatic test_5mhz();
    run_cfg(1, 14, "R10");
  endtask

  task automatic test_field_mask();
    run_cfg(7'h71, 3, "R11");
  endtask

  task automatic test_ticks();
    int bad = 0;
    logic prev;
    write_cfg(1'b0, 2);
    write_cfg(1'b1, 5);
    prev = sclk;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bit_tick != (sclk != prev)) bad++;
      prev = sclk;
    end
    check(bad == 0, "R6", "tick mismatches", bad, 0);
  endtask

  task automatic test_no_runt();
    int h = 0;
    int l = 0;
    write_cfg(1'b0, 0);
    write_cfg(1'b1, 9);
    wait_rise();
    wait_rise();
    write_cfg(1'b1, 3);
    while (sclk) begin h++; @(negedge clk); end
    while (!sclk) begin l++; @(negedge clk); end
    check(h == 4, "R7", "rest of high half", h, 4);
    check(l == 5, "R7", "low half after write", l, 5);
    h = 0;
    while (sclk) begin h++; @(negedge clk); end
    check(h == 2, "R7", "next high half", h, 2);
  endtask

  task automatic test_enable();
    int n = 0;
    int bad = 0;
    en = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && bit_tick == 1'b0, "R8", "idle outputs",
          int'(sclk) + int'(bit_tick), 0);
    write_cfg(1'b0, 0);
    write_cfg(1'b1, 5);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sclk || bit_tick) bad++;
    end
    check(bad == 0, "R8", "active samples while idle", bad, 0);
    en = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!sclk && n < 100);
    check(n == 3, "R8", "cycles to first rise", n, 3);
    n = 0;
    while (sclk) begin n++; @(negedge clk); end
    check(n == 3, "R9", "first high half", n, 3);
    n = 0;
    while (!sclk) begin n++; @(negedge clk); end
    check(n == 3, "R9", "first low half", n, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    test_divides();
    test_5mhz();
    test_field_mask();
    test_ticks();
    test_no_runt();
    test_enable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule